// File: doc/BRIEF.md
# Bit-Serial (7,4) Cyclic Encoder and Checker

This block is a serial engine for the binary cyclic code generated by p^3 + p + 1, written as the divisor 1011. It has 7-bit codewords, 4 message bits and 3 check bits. A single 3-bit shift register serves two purposes. As a polynomial divider it produces the systematic check bits and checks received words. As a polynomial multiplier it forms the non-systematic codeword M(p)·G(p). The mode captured at the start of each block selects between the two.

A block begins with a one-cycle `start` pulse. That pulse captures `mode` and clears the shift register. Data bits then arrive on `in_bit` in the cycles where `in_valid` is high. Bits travel highest power of p first, in both directions. In the two encode modes the block takes 4 bits and sends 7 bits on `out_bit`/`out_valid`. In check mode it takes 7 bits and then raises `done` for one cycle, with `pass` showing whether the remainder was zero.

Top module: `cyc_codec`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `busy`, `out_valid`, `done` and `pass` are 0. A reset during a block abandons that block.
- R2: When `mode`=2'b00 (systematic), each absorbed message bit appears on `out_bit` with `out_valid` in the cycle after it is absorbed. The remainder of p^3·M(p) divided by G(p) follows, highest power first. Examples: 1110 gives 1110100 and 1010 gives 1010011.
- R3: In the encode modes, the last 3 output bits come out in the 3 cycles right after the 4th message bit, with no idle cycle between. `in_valid` and `in_bit` are ignored in those cycles.
- R4: When `mode`=2'b01 (non-systematic), the 7 output bits are the GF(2) product M(p)·G(p), highest power first. Examples: 1001 gives 1010011 and 0110 gives 0111010.
- R5: When `mode[1]`=1 (check, for 2'b10 and 2'b11), the block divides the 7 received bits by G(p). `pass`=1 when the remainder is zero and 0 otherwise. For example, 1110100 passes and 1110101 fails.
- R6: In check mode, `done` is high for exactly one cycle: the cycle after the 7th bit is absorbed. `pass` is 0 whenever `done` is 0. `out_valid` stays 0 for the whole block.
- R7: `start` clears the shift register and restarts the block, even in the middle of a block. `in_valid` is ignored in the `start` cycle and while the block is idle. Idle cycles between data bits are allowed while bits are being absorbed.
- R8: In every mode, bit streams carry the highest power of p first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a block: clears the register and captures `mode` |
| mode | input | 2 | 00 systematic encode, 01 non-systematic encode, 1x check |
| in_valid | input | 1 | `in_bit` carries a data bit this cycle |
| in_bit | input | 1 | Serial data in, highest power first |
| out_valid | output | 1 | `out_bit` carries a codeword bit |
| out_bit | output | 1 | Serial codeword out, highest power first |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle strobe ending a check block |
| pass | output | 1 | Remainder was zero; valid with `done` |

## Verification
On every cycle, the assertions check the per-cycle rules. These are: the echo of each systematic message bit one cycle later, the unbroken run of output during the flush, the one-cycle `done` pulse with `pass` confined to it, no output in check mode, and `start` entering the busy state. The assertions cannot see the arithmetic itself. The check-bit values, the product codewords and the remainder-zero verdict come only from the bench's scenarios. Those scenarios sweep all 16 messages in both encode modes and compare against remainders and products computed in the bench. The same holds for junk input during the flush, gapped input, a restart in mid-block, and the third mode code.

// File: rtl/cyc_codec.sv
module cyc_codec #(
  parameter int          Q     = 3,
  parameter int          K     = 4,
  parameter logic [Q-1:0] G_LOW = 3'b011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       out_valid,
  output logic       out_bit,
  output logic       busy,
  output logic       done,
  output logic       pass
);
  localparam int N  = K + Q;
  localparam int CW = $clog2(N + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_FLUSH} st_t;

  st_t          st;
  logic [1:0]   mode_q;
  logic [Q-1:0] sr;
  logic [CW-1:0] cnt;
  logic [Q-1:0] mul_taps;
  logic [Q-1:0] div_nxt;
  logic         fb, mul_out, is_chk, is_sys, last_in;

  for (genvar j = 0; j < Q; j++) begin : g_taps
    assign mul_taps[j] = G_LOW[Q-1-j];
  end

  assign is_chk  = mode_q[1];
  assign is_sys  = (mode_q == 2'b00);
  assign fb      = in_bit ^ sr[Q-1];
  assign div_nxt = {sr[Q-2:0], 1'b0} ^ ({Q{fb}} & G_LOW);
  assign mul_out = in_bit ^ (^(sr & mul_taps));
  assign last_in = is_chk ? (cnt == CW'(N - 1)) : (cnt == CW'(K - 1));
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mode_q    <= 2'b00;
      sr        <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      if (start) begin
        st     <= S_LOAD;
        mode_q <= mode;
        sr     <= '0;
        cnt    <= '0;
      end else begin
        case (st)
          S_LOAD: if (in_valid) begin
            cnt <= cnt + 1'b1;
            sr  <= (is_sys || is_chk) ? div_nxt : {sr[Q-2:0], in_bit};
            if (!is_chk) begin
              out_valid <= 1'b1;
              out_bit   <= is_sys ? in_bit : mul_out;
            end
            if (last_in) begin
              cnt <= '0;
              if (is_chk) begin
                done <= 1'b1;
                pass <= (div_nxt == '0);
                st   <= S_IDLE;
              end else begin
                st <= S_FLUSH;
              end
            end
          end
          S_FLUSH: begin
            out_valid <= 1'b1;
            out_bit   <= is_sys ? sr[Q-1] : ^(sr & mul_taps);
            sr        <= {sr[Q-2:0], 1'b0};
            cnt       <= cnt + 1'b1;
            if (cnt == CW'(Q - 1)) begin
              cnt <= '0;
              st  <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !out_valid && !done && !pass));

  p_echo_msg_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOAD && !start && in_valid && mode_q == 2'b00)
      |=> (out_valid && out_bit == $past(in_bit)));

  p_flush_contig_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_FLUSH && !start) |=> out_valid);

  p_pass_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_no_out_in_check_r6: assert property (@(posedge clk) disable iff (rst)
    !(done && out_valid));

  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: tb/cyc_codec_tb_top.sv
module cyc_codec_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_valid, out_bit, busy, done, pass;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [6:0] acc;
  int nout, ndone, done_idx, cyc_idx;
  logic last_pass;

  always #4 clk = ~clk;

  cyc_codec dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_bit(out_bit),
    .busy(busy), .done(done), .pass(pass)
  );

  function automatic logic [6:0] f_sys(input logic [3:0] m);
    logic [6:0] w;
    w = {m, 3'b000};
    for (int i = 6; i >= 3; i--) if (w[i]) w ^= (7'b0001011 << (i - 3));
    return {m, w[2:0]};
  endfunction

  function automatic logic [6:0] f_mul(input logic [3:0] m);
    logic [6:0] p;
    p = '0;
    for (int i = 0; i < 4; i++) if (m[i]) p ^= (7'b0001011 << i);
    return p;
  endfunction

  function automatic logic f_div_ok(input logic [6:0] r);
    logic [6:0] w;
    w = r;
    for (int i = 6; i >= 3; i--) if (w[i]) w ^= (7'b0001011 << (i - 3));
    return (w[2:0] == 3'b000);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic b);
    in_valid = v;
    in_bit   = b;
    @(negedge clk);
    cyc_idx++;
    if (out_valid) begin
      acc = {acc[5:0], out_bit};
      nout++;
    end
    if (done) begin
      ndone++;
      last_pass = pass;
      done_idx  = cyc_idx;
    end
  endtask

  task automatic begin_blk(input logic [1:0] md);
    start = 1'b1;
    mode = md;
    in_valid = 1'b1;
    in_bit = 1'b1;
    @(negedge clk);
    start = 1'b0;
    acc = '0; nout = 0; ndone = 0; done_idx = 0; cyc_idx = 0; last_pass = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !done && !pass, "R1 reset state", {busy, out_valid, done, pass}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !out_valid, "R1 after release", {busy, out_valid}, 0);
    begin_blk(2'b00);
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 mid-block reset", {busy, out_valid, done}, 0);
  endtask

  task automatic t_enc(input logic [1:0] md, input logic [3:0] m, input bit gaps, input string tag);
    logic [6:0] exp;
    int n7;
    exp = (md == 2'b00) ? f_sys(m) : f_mul(m);
    begin_blk(md);
    for (int i = 3; i >= 0; i--) begin
      if (gaps) cycle(1'b0, 1'b1);
      cycle(1'b1, m[i]);
    end
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b1);
    n7 = nout;
    cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b1);
    chk(acc == exp && nout == 7, tag, acc, exp);
    chk(n7 == 7, "R3 contiguous flush", n7, 7);
    chk(!busy, "R3 idle after flush", busy, 0);
  endtask

  task automatic t_chk(input logic [1:0] md, input logic [6:0] w, input string tag);
    logic expp;
    expp = f_div_ok(w);
    begin_blk(md);
    for (int i = 6; i >= 0; i--) cycle(1'b1, w[i]);
    cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b1);
    chk(ndone == 1 && last_pass == expp, tag, last_pass, expp);
    chk(done_idx == 7, "R6 done timing", done_idx, 7);
    chk(nout == 0, "R6 no output in check", nout, 0);
  endtask

  task automatic t_restart;
    begin_blk(2'b01);
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b1);
    begin_blk(2'b00);
    for (int i = 3; i >= 0; i--) cycle(1'b1, i[0] ? 1'b1 : 1'b0);
    repeat (4) cycle(1'b0, 1'b0);
    chk(acc == 7'b1010011 && nout == 7, "R7 restart mid-block", acc, 7'b1010011);
    acc = '0; nout = 0;
    repeat (5) cycle(1'b1, 1'b1);
    chk(nout == 0 && !busy, "R7 idle input ignored", nout, 0);
  endtask

  initial begin
    t_reset();
    t_enc(2'b00, 4'b1110, 1'b0, "R2 sys 1110");
    t_enc(2'b00, 4'b1010, 1'b0, "R2 sys 1010");
    chk(f_sys(4'b1110) == 7'b1110100, "R8 bench model order", f_sys(4'b1110), 7'b1110100);
    for (int m = 0; m < 16; m++) t_enc(2'b00, m[3:0], 1'b0, "R2 sys sweep");
    t_enc(2'b00, 4'b1101, 1'b1, "R7 sys with gaps");
    t_enc(2'b01, 4'b1001, 1'b0, "R4 nsys 1001");
    t_enc(2'b01, 4'b0110, 1'b0, "R4 nsys 0110");
    for (int m = 0; m < 16; m++) t_enc(2'b01, m[3:0], 1'b0, "R4 nsys sweep");
    t_enc(2'b01, 4'b1011, 1'b1, "R7 nsys with gaps");
    t_chk(2'b10, 7'b1110100, "R5 check 1110100 pass");
    t_chk(2'b10, 7'b1110101, "R5 check 1110101 fail");
    t_chk(2'b10, 7'b0000000, "R5 check zero word");
    t_chk(2'b10, 7'b1000000, "R5 check single bit high");
    t_chk(2'b11, 7'b0111010, "R8 mode 11 acts as check");
    t_chk(2'b11, 7'b0111011, "R8 mode 11 reject");
    t_restart();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule